// File: doc/BRIEF.md
# Programmable Bidirectional Pad Cell

This block models a single configurable pad cell at the edge of a programmable logic fabric. Static configuration inputs set its behaviour. Two core signals are ORed, and the result goes through a polarity stage into a three-state driver on the pad. The pad level returns to the core in two ways: as a live combinational copy, and through a capture register with clock-enable and an asynchronous reset.

Each of four control roles has its own configuration multiplexer: output enable, register clock, clock-enable and reset. Each multiplexer picks a per-cell signal, one of two shared global networks, or a fixed constant. When the output enable is tied on, the capture register samples the level the cell is driving itself. This gives the core registered feedback from an otherwise unused pin.

Top module: `pio_cell`

## Requirements
- R1: Output mode 00 (active-high) with the output enable asserted drives the pad with `or_a | or_b`.
- R2: Output mode 01 (active-low) with the output enable asserted drives the pad with `~(or_a | or_b)`.
- R3: Output mode 10 (open-drain inverting) with the output enable asserted pulls the pad to 0 when `or_a | or_b` is 1 and leaves it undriven otherwise, so the pull-up makes it read 1. The cell never drives a 1 in this mode.
- R4: Output mode 11 leaves the pad undriven at all times, whatever the output enable and the OR inputs are.
- R5: With the selected output enable at 0, the pad is undriven in every output mode.
- R6: The output-enable source field selects as follows: 00 selects `oe_local`, 01 selects `gnet[0]`, 10 selects `gnet[1]` and 11 selects constant 1.
- R7: `in_comb` always equals the pad level. This holds while the cell drives the pad, and while an external agent or the pull-up sets it.
- R8: On a rising edge of the selected clock, the register loads the pad level when the selected enable is 1. It holds its value when the enable is 0.
- R9: The selected reset is active high and asynchronous. It clears `in_reg` to 0 without a clock edge. Reset source code 11 is constant 0, so no reset input affects the register.
- R10: The clock-source and enable-source fields use the same codes: 00 local, 01 `gnet[0]`, 10 `gnet[1]`. For the clock, 11 is constant 0, so no edge reaches the register. For the enable, 11 is constant 1.
- R11: With the output-enable source at 11, a clock edge makes `in_reg` load the level the cell itself is driving on the pad, in each output mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_out_mode | input | 2 | Output mode: 00 active-high, 01 active-low, 10 open-drain inverting, 11 off |
| cfg_oe_src | input | 2 | Output-enable source select |
| cfg_clk_src | input | 2 | Register clock source select |
| cfg_ce_src | input | 2 | Register clock-enable source select |
| cfg_rst_src | input | 2 | Register reset source select |
| or_a | input | 1 | First OR input from the core |
| or_b | input | 1 | Second OR input from the core |
| oe_local | input | 1 | Per-cell output enable |
| clk_local | input | 1 | Per-cell register clock |
| ce_local | input | 1 | Per-cell register clock-enable |
| rst_local | input | 1 | Per-cell register reset, active high |
| gnet | input | 2 | The two global networks |
| pad | inout | 1 | The pad |
| in_comb | output | 1 | Combinational pad level to the core |
| in_reg | output | 1 | Registered pad level to the core |

## Verification
The output path is driven with random output modes, OR inputs, output-enable sources and global-network levels. This tells a correct polarity apart from an inverted one, and a released pad apart from one driven high. When the cell releases the pad, an external driver randomly forces 0 or 1, which shows that `in_comb` follows the pad rather than the internal drive value. Directed sequences then pulse each clock, enable and reset source one at a time while the others stay quiet, which separates a correct selector from one wired to a neighbouring source. A last sequence checks registered feedback in every driving mode.

// File: rtl/pio_pkg.sv
package pio_pkg;

  typedef enum logic [1:0] {
    SRC_LOCAL = 2'b00,
    SRC_GNET0 = 2'b01,
    SRC_GNET1 = 2'b10,
    SRC_CONST = 2'b11
  } src_sel_e;

  typedef enum logic [1:0] {
    OM_HIGH = 2'b00,
    OM_LOW  = 2'b01,
    OM_OD   = 2'b10,
    OM_OFF  = 2'b11
  } out_mode_e;

  localparam int unsigned GNET_COUNT = 2;

endpackage

// File: rtl/pio_src_mux.sv
module pio_src_mux
  import pio_pkg::*;
#(
  parameter logic TIE_VALUE = 1'b0,
  parameter int unsigned N_GNET = GNET_COUNT
) (
  input  src_sel_e          sel,
  input  logic              local_in,
  input  logic [N_GNET-1:0] gnet,
  output logic              y
);

  always_comb begin
    unique case (sel)
      SRC_LOCAL: y = local_in;
      SRC_GNET0: y = gnet[0];
      SRC_GNET1: y = gnet[1];
      default:   y = TIE_VALUE;
    endcase
  end

endmodule

// File: rtl/pio_out_stage.sv
module pio_out_stage
  import pio_pkg::*;
(
  input  out_mode_e mode,
  input  logic      oe,
  input  logic      a,
  input  logic      b,
  output logic      drv_en,
  output logic      drv_val
);

  logic or_q;

  always_comb begin
    or_q    = a | b;
    drv_en  = 1'b0;
    drv_val = 1'b0;
    if (oe) begin
      unique case (mode)
        OM_HIGH: begin drv_en = 1'b1; drv_val = or_q;  end
        OM_LOW:  begin drv_en = 1'b1; drv_val = ~or_q; end
        OM_OD:   begin drv_en = or_q; drv_val = 1'b0;  end
        default: begin drv_en = 1'b0; drv_val = 1'b0;  end
      endcase
    end
  end

  always_comb begin
    if (mode == OM_OD && drv_en)
      AST_OD_NEVER_HIGH: assert (drv_val == 1'b0); // R3
    if (mode == OM_OFF)
      AST_OFF_NO_DRIVE: assert (!drv_en); // R4
    if (oe == 1'b0)
      AST_NO_OE_NO_DRIVE: assert (!drv_en); // R5
  end

endmodule

// File: rtl/pio_in_reg.sv
module pio_in_reg #(
  parameter logic CLEAR_VALUE = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic ce,
  input  logic d,
  output logic q
);

  always_ff @(posedge clk or posedge rst) begin
    if (rst)     q <= CLEAR_VALUE;
    else if (ce) q <= d;
  end

endmodule

// File: rtl/pio_cell.sv
module pio_cell
  import pio_pkg::*;
(
  input  logic [1:0] cfg_out_mode,
  input  logic [1:0] cfg_oe_src,
  input  logic [1:0] cfg_clk_src,
  input  logic [1:0] cfg_ce_src,
  input  logic [1:0] cfg_rst_src,
  input  logic       or_a,
  input  logic       or_b,
  input  logic       oe_local,
  input  logic       clk_local,
  input  logic       ce_local,
  input  logic       rst_local,
  input  logic [1:0] gnet,
  inout  wire        pad,
  output logic       in_comb,
  output logic       in_reg
);

  localparam int unsigned NG = GNET_COUNT;

  logic oe_eff, clk_eff, ce_eff, rst_eff;
  logic drv_en, drv_val;

  pio_src_mux #(.TIE_VALUE(1'b1), .N_GNET(NG)) u_oe_mux (
    .sel(src_sel_e'(cfg_oe_src)), .local_in(oe_local), .gnet(gnet), .y(oe_eff)
  );

  pio_src_mux #(.TIE_VALUE(1'b0), .N_GNET(NG)) u_clk_mux (
    .sel(src_sel_e'(cfg_clk_src)), .local_in(clk_local), .gnet(gnet), .y(clk_eff)
  );

  pio_src_mux #(.TIE_VALUE(1'b1), .N_GNET(NG)) u_ce_mux (
    .sel(src_sel_e'(cfg_ce_src)), .local_in(ce_local), .gnet(gnet), .y(ce_eff)
  );

  pio_src_mux #(.TIE_VALUE(1'b0), .N_GNET(NG)) u_rst_mux (
    .sel(src_sel_e'(cfg_rst_src)), .local_in(rst_local), .gnet(gnet), .y(rst_eff)
  );

  pio_out_stage u_out (
    .mode(out_mode_e'(cfg_out_mode)),
    .oe(oe_eff),
    .a(or_a),
    .b(or_b),
    .drv_en(drv_en),
    .drv_val(drv_val)
  );

  assign pad     = drv_en ? drv_val : 1'bz;
  assign in_comb = pad;

  pio_in_reg #(.CLEAR_VALUE(1'b0)) u_reg (
    .clk(clk_eff),
    .rst(rst_eff),
    .ce(ce_eff),
    .d(pad),
    .q(in_reg)
  );

  always_comb begin
    if (cfg_oe_src == 2'b11 && (cfg_out_mode == 2'b00 || cfg_out_mode == 2'b01))
      AST_TIED_OE_DRIVES: assert (drv_en); // R6
    if (cfg_oe_src == 2'b00 && cfg_out_mode == 2'b00 && oe_local == 1'b1)
      AST_LOCAL_OE_DRIVES: assert (drv_en); // R6
  end

endmodule

// File: tb/tb_pio_cell.sv
`timescale 1ns/1ps
module tb_pio_cell;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [1:0] cfg_out_mode, cfg_oe_src, cfg_clk_src, cfg_ce_src, cfg_rst_src;
  logic or_a, or_b, oe_local, clk_local, ce_local, rst_local;
  logic [1:0] gnet;
  logic ext_en, ext_val;
  logic in_comb, in_reg;
  wire  pad;

  pullup pu_pad (pad);
  assign pad = ext_en ? ext_val : 1'bz;

  pio_cell dut (
    .cfg_out_mode(cfg_out_mode), .cfg_oe_src(cfg_oe_src), .cfg_clk_src(cfg_clk_src),
    .cfg_ce_src(cfg_ce_src), .cfg_rst_src(cfg_rst_src),
    .or_a(or_a), .or_b(or_b), .oe_local(oe_local), .clk_local(clk_local),
    .ce_local(ce_local), .rst_local(rst_local), .gnet(gnet),
    .pad(pad), .in_comb(in_comb), .in_reg(in_reg)
  );

  int n_checks = 0;
  int n_errors = 0;
  logic expect_q;

  task automatic chk(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic pick(input logic [1:0] sel, input logic loc,
                                input logic [1:0] g, input logic tie);
    case (sel)
      2'b00: return loc;
      2'b01: return g[0];
      2'b10: return g[1];
      default: return tie;
    endcase
  endfunction

  // returns {drives, value}
  function automatic logic [1:0] model_drive(input logic [1:0] mode, input logic oe,
                                             input logic a, input logic b);
    logic o;
    o = a | b;
    if (!oe) return 2'b00;
    case (mode)
      2'b00: return {1'b1, o};
      2'b01: return {1'b1, ~o};
      2'b10: return o ? 2'b10 : 2'b00;
      default: return 2'b00;
    endcase
  endfunction

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic pulse_src(input int s);
    case (s)
      0: clk_local = 1'b1;
      1: gnet[0]   = 1'b1;
      default: gnet[1] = 1'b1;
    endcase
    #3;
    clk_local = 1'b0;
    gnet      = 2'b00;
    #3;
  endtask

  task automatic pulse_rst(input int s);
    case (s)
      0: rst_local = 1'b1;
      1: gnet[0]   = 1'b1;
      default: gnet[1] = 1'b1;
    endcase
    #1;
  endtask

  task automatic release_rst();
    rst_local = 1'b0;
    gnet      = 2'b00;
    #2;
  endtask

  initial begin
    cfg_out_mode = 2'b11; cfg_oe_src = 2'b00; cfg_clk_src = 2'b11;
    cfg_ce_src = 2'b11; cfg_rst_src = 2'b00;
    or_a = 0; or_b = 0; oe_local = 0; clk_local = 0; ce_local = 0;
    rst_local = 1; gnet = 2'b00; ext_en = 0; ext_val = 0;
    void'($urandom(32'h5EED_1234));
    repeat (2) @(negedge clk);
    rst_local = 0;
    settle();
    chk("R9 reset state in_reg", in_reg, 1'b0);
    chk("R4 idle pad pulled up", in_comb, 1'b1);

    // random output path
    cfg_rst_src = 2'b11;
    for (int i = 0; i < 300; i++) begin
      logic oe_x;
      logic [1:0] dv;
      string tag;
      cfg_out_mode = 2'($urandom);
      cfg_oe_src   = 2'($urandom);
      oe_local     = 1'($urandom);
      gnet         = 2'($urandom);
      or_a         = 1'($urandom);
      or_b         = 1'($urandom);
      oe_x = pick(cfg_oe_src, oe_local, gnet, 1'b1);
      dv   = model_drive(cfg_out_mode, oe_x, or_a, or_b);
      ext_en  = dv[1] ? 1'b0 : 1'($urandom);
      ext_val = 1'($urandom);
      settle();
      case (cfg_out_mode)
        2'b00: tag = "R1 active-high";
        2'b01: tag = "R2 active-low";
        2'b10: tag = "R3 open-drain";
        default: tag = "R4 off";
      endcase
      if (!oe_x && cfg_out_mode != 2'b11) tag = "R5 oe low";
      if (!dv[1] && ext_en) tag = "R7 external drive";
      chk(tag, in_comb, dv[1] ? dv[0] : (ext_en ? ext_val : 1'b1));
    end
    ext_en = 0; gnet = 2'b00;

    // R6 directed oe sources, active-low with OR=1
    cfg_out_mode = 2'b01; or_a = 1; or_b = 0;
    for (int s = 0; s < 3; s++) begin
      cfg_oe_src = 2'(s); oe_local = 0; gnet = 2'b00;
      case (s)
        0: oe_local = 1'b1;
        1: gnet[0] = 1'b1;
        default: gnet[1] = 1'b1;
      endcase
      settle();
      chk("R6 selected oe on", in_comb, 1'b0);
      oe_local = 1'b1; gnet = 2'b11;
      case (s)
        0: oe_local = 1'b0;
        1: gnet[0] = 1'b0;
        default: gnet[1] = 1'b0;
      endcase
      settle();
      chk("R6 selected oe off", in_comb, 1'b1);
    end
    cfg_oe_src = 2'b11; oe_local = 0; gnet = 2'b00;
    settle();
    chk("R6 tied oe on", in_comb, 1'b0);

    // register capture from each clock source
    cfg_out_mode = 2'b11; cfg_oe_src = 2'b00; ext_en = 1;
    cfg_ce_src = 2'b11; cfg_rst_src = 2'b11;
    expect_q = 1'b0;
    for (int s = 0; s < 3; s++) begin
      cfg_clk_src = 2'(s);
      ext_val = (s % 2 == 0);
      settle();
      pulse_src(s);
      expect_q = ext_val;
      chk("R10 clock source capture", in_reg, expect_q);
    end
    cfg_clk_src = 2'b11; ext_val = ~expect_q;
    settle();
    pulse_src(0); pulse_src(1); pulse_src(2);
    chk("R10 tied clock no capture", in_reg, expect_q);

    // clock-enable from each source
    cfg_clk_src = 2'b00;
    for (int s = 0; s < 3; s++) begin
      cfg_ce_src = 2'(s);
      ce_local = 0;
      ext_val = ~expect_q;
      settle();
      if (s == 0) pulse_src(0);
      else begin
        clk_local = 1; #3; clk_local = 0; #3;
      end
      chk("R8 enable low holds", in_reg, expect_q);
      case (s)
        0: ce_local = 1'b1;
        1: gnet[0] = 1'b1;
        default: gnet[1] = 1'b1;
      endcase
      #2;
      clk_local = 1; #3; clk_local = 0; #3;
      expect_q = ext_val;
      chk("R8 enable high captures", in_reg, expect_q);
      ce_local = 0; gnet = 2'b00;
    end

    // asynchronous reset from each source
    cfg_ce_src = 2'b11;
    for (int s = 0; s < 3; s++) begin
      cfg_rst_src = 2'b11; ext_val = 1;
      settle();
      pulse_src(0);
      chk("R8 capture before reset", in_reg, 1'b1);
      cfg_rst_src = 2'(s);
      #2;
      pulse_rst(s);
      chk("R9 async reset clears", in_reg, 1'b0);
      release_rst();
    end
    cfg_rst_src = 2'b11;
    settle();
    pulse_src(0);
    pulse_rst(0); release_rst();
    pulse_rst(1); release_rst();
    pulse_rst(2); release_rst();
    chk("R9 tied reset has no effect", in_reg, 1'b1);

    // registered feedback of own output
    ext_en = 0; cfg_oe_src = 2'b11; cfg_clk_src = 2'b00; cfg_ce_src = 2'b11;
    cfg_out_mode = 2'b00; or_a = 0; or_b = 0;
    settle(); pulse_src(0);
    chk("R11 feedback active-high 0", in_reg, 1'b0);
    or_b = 1;
    settle(); pulse_src(0);
    chk("R11 feedback active-high 1", in_reg, 1'b1);
    cfg_out_mode = 2'b01;
    settle(); pulse_src(0);
    chk("R11 feedback active-low", in_reg, 1'b0);
    cfg_out_mode = 2'b10; or_b = 0;
    settle(); pulse_src(0);
    chk("R11 feedback open-drain released", in_reg, 1'b1);
    or_a = 1;
    settle(); pulse_src(0);
    chk("R11 feedback open-drain low", in_reg, 1'b0);

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule